// File: doc/BRIEF.md
# Transmit Margining Segment Controller

This block produces the digital settings for one tap of a segmented differential transmitter. Each tap driver is split into three segments. The data segment carries half of the tap current. An offset segment and a common-mode segment share the other half. In normal write operation all three segments carry data. For margin testing the block repurposes the offset segment to inject a static differential level onto the link. It also trims the common-mode segment so that the output common-mode level stays put while the offset is swept.

Three modes are supported. Write-margin offsets the local transmitter's own signal. Read-margin turns off the data segment, asks the far-end transmitter to drop to half swing, and scales the offset and common-mode currents by a far-end-to-local swing ratio. A request is taken in on an update strobe. The registered segment settings change exactly one cycle later, all at once, so the analog segments never see a partial word. One instance is placed per FIR tap.

Top module: `tx_margin_seg_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are the normal-mode settings of R2, with ofs_clip_o = 0.
- R2: A latched mode of 2'b00 gives normal write. Mode 2'b11 is also treated as normal write. In normal write: seg_en_o = 3'b111, seg_sel_o = 0, ofs_code_o = BUDGET/2 (rounded down), cm_code_o = BUDGET - BUDGET/2, and far_half_swing_o = 0.
- R3: Mode 2'b01 gives write-margin. The segment fields are: seg_en_o bit 0 = data, bit 1 = offset, bit 2 = common-mode; seg_sel_o[1:0] = data, [3:2] = offset, [5:4] = common-mode. In write-margin all three are enabled and the data select is 2'b00 (carry data). The offset select is 2'b01 (positive input tied high) when polarity = 0, and 2'b10 (negative input tied high) when polarity = 1. The common-mode select is 2'b11 (both inputs high). far_half_swing_o = 0.
- R4: In write-margin, ofs_code_o = min(request, BUDGET) and cm_code_o = BUDGET - ofs_code_o, so the two always sum to BUDGET.
- R5: Mode 2'b10 gives read-margin. The data segment is disabled with select 2'b00. The offset and common-mode segments are enabled with the selects of R3. far_half_swing_o = 1.
- R6: In read-margin, with c = min(request, BUDGET) and ratio r read as r/2^RATIO_W: ofs_code_o = floor(c*r/2^RATIO_W) and cm_code_o = floor(BUDGET*r/2^RATIO_W) - ofs_code_o.
- R7: In both margin modes, ofs_clip_o = 1 exactly when the request exceeds BUDGET. In normal write it is 0.
- R8: Inputs are captured at a rising edge where upd_i = 1. The outputs take the new settings at the following rising edge. Input changes without an update strobe leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe: capture the request at this edge |
| mode_i | input | 2 | Mode request (00 normal, 01 write-margin, 10 read-margin, 11 normal) |
| pol_i | input | 1 | Offset polarity |
| ofs_req_i | input | CODE_W | Requested offset magnitude code |
| ratio_i | input | RATIO_W | Far-end to local swing ratio, in units of 1/2^RATIO_W |
| seg_en_o | output | 3 | Segment enables (data, offset, common-mode) |
| seg_sel_o | output | 6 | Per-segment drive select, two bits per segment |
| ofs_code_o | output | CODE_W | Offset segment tail-current code |
| cm_code_o | output | CODE_W | Common-mode segment tail-current code |
| far_half_swing_o | output | 1 | Request to put the far-end transmitter in half swing |
| ofs_clip_o | output | 1 | Offset request exceeded BUDGET and was clamped |

## Verification
The bench builds the block with CODE_W = 6, BUDGET = 40 and RATIO_W = 4. With these values, requests from 41 to 63 fall in the clamp region. All sixteen ratio steps, including zero and the nominal 11/16, can be reached. The odd-free budget of 40 makes the normal-mode split exact. Random requests drawn over the full code range exercise the floor rounding of the read-margin scaling on both the offset and the budget term.

// File: rtl/txm_pkg.sv
// Package: shared types and segment rules for the transmit margining
// segment controller. Assumes three segments per tap in a fixed order:
// data, offset, common-mode.
package txm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_WMARG  = 2'b01,
        MODE_RMARG  = 2'b10,
        MODE_RSVD   = 2'b11
    } txm_mode_e;

    localparam int NUM_SEG   = 3;
    localparam int SEG_DATA  = 0;
    localparam int SEG_OFS   = 1;
    localparam int SEG_CM    = 2;

    // Drive select: bit0 forces the positive input high, bit1 the negative.
    localparam logic [1:0] SEL_DATA = 2'b00;
    localparam logic [1:0] SEL_POS  = 2'b01;
    localparam logic [1:0] SEL_NEG  = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } seg_ctrl_t;

    // Segment rule: enable and drive select of segment idx for a mode/polarity.
    function automatic seg_ctrl_t seg_rule(input txm_mode_e m, input logic pol,
                                           input int idx);
        seg_ctrl_t r;
        r.en  = 1'b1;
        r.sel = SEL_DATA;
        if (m == MODE_WMARG || m == MODE_RMARG) begin
            if (idx == SEG_DATA) begin
                r.en = (m == MODE_WMARG);
            end else if (idx == SEG_OFS) begin
                r.sel = pol ? SEL_NEG : SEL_POS;
            end else begin
                r.sel = SEL_BOTH;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/txm_shadow.sv
// Shadow register: holds the request captured at an update strobe and
// produces a one-cycle apply pulse for the following edge.
// Assumes upd_i is synchronous to clk.
module txm_shadow #(
    parameter int CODE_W  = 6,
    parameter int RATIO_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_i,
    input  logic [1:0]            mode_i,
    input  logic                  pol_i,
    input  logic [CODE_W-1:0]     ofs_req_i,
    input  logic [RATIO_W-1:0]    ratio_i,
    output txm_pkg::txm_mode_e    mode_q,
    output logic                  pol_q,
    output logic [CODE_W-1:0]     req_q,
    output logic [RATIO_W-1:0]    ratio_q,
    output logic                  apply_q
);
    import txm_pkg::*;

    // Capture the request on the strobe and delay the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_NORMAL;
            pol_q   <= 1'b0;
            req_q   <= '0;
            ratio_q <= '0;
            apply_q <= 1'b0;
        end else begin
            apply_q <= upd_i;
            if (upd_i) begin
                mode_q  <= txm_mode_e'(mode_i);
                pol_q   <= pol_i;
                req_q   <= ofs_req_i;
                ratio_q <= ratio_i;
            end
        end
    end
endmodule

// File: rtl/txm_code_calc.sv
// Code calculator: clamps the offset request to the budget, applies the
// swing ratio in read-margin, and derives the common-mode code so that
// offset plus common-mode is constant for a given mode and ratio.
// Assumes BUDGET fits in CODE_W bits.
module txm_code_calc #(
    parameter int CODE_W  = 6,
    parameter int BUDGET  = 40,
    parameter int RATIO_W = 4
) (
    input  txm_pkg::txm_mode_e    mode,
    input  logic [CODE_W-1:0]     req,
    input  logic [RATIO_W-1:0]    ratio,
    output logic [CODE_W-1:0]     ofs_code,
    output logic [CODE_W-1:0]     cm_code,
    output logic                  clip
);
    import txm_pkg::*;

    localparam int PROD_W = CODE_W + RATIO_W;
    localparam logic [CODE_W-1:0] BUD_C    = CODE_W'(BUDGET);
    localparam logic [CODE_W-1:0] NORM_OFS = CODE_W'(BUDGET / 2);
    localparam logic [CODE_W-1:0] NORM_CM  = CODE_W'(BUDGET - BUDGET / 2);

    logic                 over;
    logic [CODE_W-1:0]    clamped;
    logic [PROD_W-1:0]    ofs_prod;
    logic [PROD_W-1:0]    bud_prod;
    logic [CODE_W-1:0]    ofs_scaled;
    logic [CODE_W-1:0]    bud_scaled;

    // Clamp the request and form the ratio-scaled offset and budget.
    always_comb begin
        over       = (req > BUD_C);
        clamped    = over ? BUD_C : req;
        ofs_prod   = PROD_W'(clamped) * PROD_W'(ratio);
        bud_prod   = PROD_W'(BUD_C) * PROD_W'(ratio);
        ofs_scaled = CODE_W'(ofs_prod >> RATIO_W);
        bud_scaled = CODE_W'(bud_prod >> RATIO_W);
    end

    // Select the codes for the mode.
    always_comb begin
        case (mode)
            MODE_WMARG: begin
                ofs_code = clamped;
                cm_code  = BUD_C - clamped;
                clip     = over;
            end
            MODE_RMARG: begin
                ofs_code = ofs_scaled;
                cm_code  = bud_scaled - ofs_scaled;
                clip     = over;
            end
            default: begin
                ofs_code = NORM_OFS;
                cm_code  = NORM_CM;
                clip     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/txm_seg_map.sv
// Segment mapper: turns mode and polarity into per-segment enable and
// drive-select bits, plus the far-end half-swing request.
// Assumes the segment order of txm_pkg.
module txm_seg_map (
    input  txm_pkg::txm_mode_e               mode,
    input  logic                             pol,
    output logic [txm_pkg::NUM_SEG-1:0]      seg_en,
    output logic [2*txm_pkg::NUM_SEG-1:0]    seg_sel,
    output logic                             half_swing
);
    import txm_pkg::*;

    // One rule lookup per segment.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        seg_ctrl_t ctl;
        always_comb ctl = seg_rule(mode, pol, g);
        assign seg_en[g]          = ctl.en;
        assign seg_sel[2*g +: 2]  = ctl.sel;
    end

    // Far end drops to half swing only while read margining.
    always_comb half_swing = (mode == MODE_RMARG);
endmodule

// File: rtl/tx_margin_seg_ctrl.sv
// Top: transmit margining segment controller for one FIR tap.
// Captures a request on upd_i, computes segment settings and codes, and
// updates all outputs together one cycle after the strobe.
// Assumes synchronous active-low reset and BUDGET < 2**CODE_W.
module tx_margin_seg_ctrl #(
    parameter int CODE_W  = 6,
    parameter int BUDGET  = 40,
    parameter int RATIO_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_i,
    input  logic [1:0]            mode_i,
    input  logic                  pol_i,
    input  logic [CODE_W-1:0]     ofs_req_i,
    input  logic [RATIO_W-1:0]    ratio_i,
    output logic [2:0]            seg_en_o,
    output logic [5:0]            seg_sel_o,
    output logic [CODE_W-1:0]     ofs_code_o,
    output logic [CODE_W-1:0]     cm_code_o,
    output logic                  far_half_swing_o,
    output logic                  ofs_clip_o
);
    import txm_pkg::*;

    localparam logic [CODE_W-1:0] RST_OFS = CODE_W'(BUDGET / 2);
    localparam logic [CODE_W-1:0] RST_CM  = CODE_W'(BUDGET - BUDGET / 2);

    txm_mode_e           mode_q;
    logic                pol_q;
    logic [CODE_W-1:0]   req_q;
    logic [RATIO_W-1:0]  ratio_q;
    logic                apply_q;

    logic [CODE_W-1:0]   ofs_nxt;
    logic [CODE_W-1:0]   cm_nxt;
    logic                clip_nxt;
    logic [NUM_SEG-1:0]  en_nxt;
    logic [2*NUM_SEG-1:0] sel_nxt;
    logic                hs_nxt;

    txm_shadow #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (upd_i),
        .mode_i   (mode_i),
        .pol_i    (pol_i),
        .ofs_req_i(ofs_req_i),
        .ratio_i  (ratio_i),
        .mode_q   (mode_q),
        .pol_q    (pol_q),
        .req_q    (req_q),
        .ratio_q  (ratio_q),
        .apply_q  (apply_q)
    );

    txm_code_calc #(.CODE_W(CODE_W), .BUDGET(BUDGET), .RATIO_W(RATIO_W)) calc_i (
        .mode    (mode_q),
        .req     (req_q),
        .ratio   (ratio_q),
        .ofs_code(ofs_nxt),
        .cm_code (cm_nxt),
        .clip    (clip_nxt)
    );

    txm_seg_map map_i (
        .mode      (mode_q),
        .pol       (pol_q),
        .seg_en    (en_nxt),
        .seg_sel   (sel_nxt),
        .half_swing(hs_nxt)
    );

    // Output register: load the whole setting word on the apply pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_en_o         <= 3'b111;
            seg_sel_o        <= '0;
            ofs_code_o       <= RST_OFS;
            cm_code_o        <= RST_CM;
            far_half_swing_o <= 1'b0;
            ofs_clip_o       <= 1'b0;
        end else if (apply_q) begin
            seg_en_o         <= en_nxt;
            seg_sel_o        <= sel_nxt;
            ofs_code_o       <= ofs_nxt;
            cm_code_o        <= cm_nxt;
            far_half_swing_o <= hs_nxt;
            ofs_clip_o       <= clip_nxt;
        end
    end
endmodule

// File: rtl/tx_margin_seg_ctrl_chk.sv
// Checker: port-level properties of the segment controller, bound to it.
module tx_margin_seg_ctrl_chk #(
    parameter int CODE_W  = 6,
    parameter int BUDGET  = 40,
    parameter int RATIO_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  upd_i,
    input logic [2:0]            seg_en_o,
    input logic [5:0]            seg_sel_o,
    input logic [CODE_W-1:0]     ofs_code_o,
    input logic [CODE_W-1:0]     cm_code_o,
    input logic                  far_half_swing_o,
    input logic                  ofs_clip_o
);
    logic is_wmarg;
    logic is_rmarg;
    int   code_sum;
    always_comb begin
        is_wmarg = seg_en_o[0] && (seg_sel_o[3:2] != 2'b00);
        is_rmarg = !seg_en_o[0];
        code_sum = int'(ofs_code_o) + int'(cm_code_o);
    end

    assert_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en_o == 3'b111 && seg_sel_o == 6'd0) |-> (!far_half_swing_o && !ofs_clip_o && code_sum == BUDGET));

    assert_wmarg_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_wmarg |-> (seg_sel_o[5:4] == 2'b11 && $countones(seg_sel_o[3:2]) == 1
                      && seg_sel_o[1:0] == 2'b00 && !far_half_swing_o));

    assert_wmarg_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_wmarg |-> (code_sum == BUDGET));

    assert_rmarg_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_rmarg |-> (far_half_swing_o && seg_en_o[2:1] == 2'b11 && seg_sel_o[5:4] == 2'b11));

    assert_rmarg_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_rmarg |-> (code_sum <= BUDGET));

    assert_clip_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_clip_o |-> (seg_sel_o[3:2] != 2'b00));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_i, 2) |-> ($stable(seg_en_o) && $stable(seg_sel_o) && $stable(ofs_code_o)
                              && $stable(cm_code_o) && $stable(ofs_clip_o)));
endmodule

bind tx_margin_seg_ctrl tx_margin_seg_ctrl_chk #(
    .CODE_W (CODE_W),
    .BUDGET (BUDGET),
    .RATIO_W(RATIO_W)
) chk_i (.*);

// File: tb/tx_margin_seg_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_margin_seg_ctrl_tb_top;
    localparam int CW  = 6;
    localparam int BUD = 40;
    localparam int RW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          pol_i = 1'b0;
    logic [CW-1:0] ofs_req_i = '0;
    logic [RW-1:0] ratio_i = '0;
    logic [2:0]    seg_en_o;
    logic [5:0]    seg_sel_o;
    logic [CW-1:0] ofs_code_o;
    logic [CW-1:0] cm_code_o;
    logic          far_half_swing_o;
    logic          ofs_clip_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expected current outputs
    logic [2:0] e_en;
    logic [5:0] e_sel;
    int         e_ofs, e_cm;
    logic       e_hs, e_clip;
    string      e_tag;

    always #2.5 clk = ~clk;

    tx_margin_seg_ctrl #(.CODE_W(CW), .BUDGET(BUD), .RATIO_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .mode_i(mode_i), .pol_i(pol_i),
        .ofs_req_i(ofs_req_i), .ratio_i(ratio_i), .seg_en_o(seg_en_o),
        .seg_sel_o(seg_sel_o), .ofs_code_o(ofs_code_o), .cm_code_o(cm_code_o),
        .far_half_swing_o(far_half_swing_o), .ofs_clip_o(ofs_clip_o)
    );

    // Expected settings from the requirements.
    task automatic model(input logic [1:0] m, input logic p, input int req, input int r);
        int c;
        int sb;
        logic [1:0] osel;
        c    = (req > BUD) ? BUD : req;
        osel = p ? 2'b10 : 2'b01;
        if (m == 2'b01) begin
            e_en = 3'b111; e_sel = {2'b11, osel, 2'b00};
            e_ofs = c; e_cm = BUD - c; e_hs = 1'b0; e_clip = (req > BUD);
            e_tag = "R3 R4 R7";
        end else if (m == 2'b10) begin
            sb = (BUD * r) >> RW;
            e_en = 3'b110; e_sel = {2'b11, osel, 2'b00};
            e_ofs = (c * r) >> RW; e_cm = sb - e_ofs; e_hs = 1'b1; e_clip = (req > BUD);
            e_tag = "R5 R6 R7";
        end else begin
            e_en = 3'b111; e_sel = 6'd0; e_ofs = BUD / 2; e_cm = BUD - BUD / 2;
            e_hs = 1'b0; e_clip = 1'b0;
            e_tag = "R2";
        end
    endtask

    task automatic check(input string tag);
        n_tests++;
        if (seg_en_o !== e_en || seg_sel_o !== e_sel || int'(ofs_code_o) != e_ofs ||
            int'(cm_code_o) != e_cm || far_half_swing_o !== e_hs || ofs_clip_o !== e_clip) begin
            n_fail++;
            $display("FAIL %s actual en=%b sel=%b ofs=%0d cm=%0d hs=%b clip=%b expected en=%b sel=%b ofs=%0d cm=%0d hs=%b clip=%b",
                     tag, seg_en_o, seg_sel_o, ofs_code_o, cm_code_o, far_half_swing_o, ofs_clip_o,
                     e_en, e_sel, e_ofs, e_cm, e_hs, e_clip);
        end
    endtask

    // Issue a request, check hold before the apply edge and the result after it.
    task automatic apply(input logic [1:0] m, input logic p, input int req, input int r);
        @(negedge clk);
        mode_i = m; pol_i = p; ofs_req_i = CW'(req); ratio_i = RW'(r); upd_i = 1'b1;
        @(negedge clk);
        upd_i = 1'b0;
        mode_i = 2'(~m); ofs_req_i = ~CW'(req);
        check("R8 hold before apply edge");
        model(m, p, req, r);
        @(negedge clk);
        check(e_tag);
    endtask

    // Change inputs with no strobe; outputs must not move.
    task automatic idle_noise();
        @(negedge clk);
        mode_i = 2'($urandom); pol_i = 1'($urandom);
        ofs_req_i = CW'($urandom); ratio_i = RW'($urandom);
        repeat (3) @(negedge clk);
        check("R8 no strobe");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model(2'b00, 1'b0, 0, 0);
        check("R1 reset state");

        apply(2'b01, 1'b0, 10, 0);      // R3 R4 positive offset
        apply(2'b01, 1'b1, 40, 0);      // R4 boundary equal to budget
        apply(2'b01, 1'b0, 41, 0);      // R7 just over budget
        apply(2'b01, 1'b1, 63, 0);      // R7 full scale
        apply(2'b01, 1'b0, 0, 0);       // R4 zero offset
        apply(2'b11, 1'b1, 63, 15);     // R2 reserved code acts as normal
        apply(2'b10, 1'b0, 30, 11);     // R6 nominal ratio
        apply(2'b10, 1'b1, 63, 15);     // R6 R7 clamp with max ratio
        apply(2'b10, 1'b0, 25, 0);      // R6 zero ratio
        apply(2'b00, 1'b0, 50, 3);      // R2 back to normal
        idle_noise();

        for (int i = 0; i < 300; i++) begin
            apply(2'($urandom), 1'($urandom), int'($urandom_range(0, 63)), int'($urandom_range(0, 15)));
            if ((i % 10) == 0) idle_noise();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule